// File: doc/BRIEF.md
# J1850 Byte-Level Link Controller

This block is the byte-sequencing core of an SAE J1850 data link controller. It sits between a CPU register interface and an abstract symbol layer. The symbol layer reports start-of-frame, received bytes, end-of-frame, lost arbitration and a ready-for-next-byte event. It accepts bytes to send and a request to close the frame. Pulse-width symbol coding, bit timing, CRC and in-frame responses belong to the symbol layer and are not part of this block.

To transmit, the CPU writes a byte into the data register. The block hands the byte to the bus when the symbol layer is ready. The CPU keeps the message going by writing the next byte each time the transmit-empty condition appears. There is no abort command. If the CPU does not refill in time, the block closes the frame (two logic-one bits and an EOF).

On receive, the block reports each incoming byte and the frame end through a priority-encoded status vector and an interrupt. An ignore bit lets the CPU skip the remainder of a frame it does not need. This bit clears itself at the next start-of-frame.

Top module: `j1850_link_ctrl`

## Requirements
- R1: After reset `stat_vec` is 0, `irq` is 0, `ign_msg` is 0 and neither `tx_valid` nor `tx_end` is high.
- R2: When the block is idle and a byte is pending, a `sym_tx_rdy` cycle starts the message. In the next cycle `tx_valid` is high for one cycle and `tx_byte` carries the pending byte.
- R3: Before the message starts, a later data write replaces the pending byte. The last value written is the one sent.
- R4: Every byte handed to the bus sets transmit-empty (`stat_vec` code 1) in the same cycle that `tx_valid` rises. A data write clears transmit-empty. Inside a message, each `sym_tx_rdy` cycle that finds a pending byte sends that byte.
- R5: Inside a message, a `sym_tx_rdy` cycle with no pending byte is an underrun. In the next cycle `tx_end` pulses for one cycle, asking for two logic ones and an EOF. No byte is sent, and the block returns to idle.
- R6: A received byte (`sym_rx_valid`) outside the block's own transmission sets receive-full (code 2) and appears on `dat_rdata`. A data read (`dat_re`) clears receive-full.
- R7: `sym_eof` sets message-complete (code 4).
- R8: While `ign_msg` is 1, received bytes and EOF set no flag and leave `dat_rdata` unchanged. Lost-arbitration and transmit-empty are not affected by the ignore bit.
- R9: Bit 0 of a control write (`ctl_ign_in`) sets or clears `ign_msg`. `sym_sof` always clears it.
- R10: `stat_vec` shows the highest pending condition, in this order: message-complete 4, lost-arbitration 3, receive-full 2, transmit-empty 1. It shows 0 when nothing is pending.
- R11: `sym_lost` during a transmission sets lost-arbitration and drops the pending byte. It also switches the block to receiving, so later `sym_tx_rdy` cycles send nothing and later bytes are reported as received.
- R12: `irq` is high exactly when the interrupt-enable bit (`ctl_ie_in`, latched by a control write) is 1 and any condition is pending.
- R13: A status read (`stat_re`) clears message-complete if it is pending. Otherwise it clears lost-arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | DW | Byte to transmit |
| dat_re | input | 1 | Data register read strobe |
| dat_rdata | output | DW | Last received byte |
| ctl_we | input | 1 | Control register write strobe |
| ctl_ign_in | input | 1 | Ignore-message value for a control write |
| ctl_ie_in | input | 1 | Interrupt-enable value for a control write |
| ign_msg | output | 1 | Current ignore-message bit |
| stat_re | input | 1 | Status vector read strobe |
| stat_vec | output | 3 | Priority-encoded status |
| irq | output | 1 | Interrupt request |
| sym_sof | input | 1 | Start-of-frame seen on the bus |
| sym_rx_valid | input | 1 | A byte was received |
| sym_rx_byte | input | DW | The received byte |
| sym_eof | input | 1 | End-of-frame seen on the bus |
| sym_lost | input | 1 | Arbitration lost |
| sym_tx_rdy | input | 1 | Symbol layer ready for the next byte |
| tx_valid | output | 1 | Byte handed to the symbol layer |
| tx_byte | output | DW | Byte to send |
| tx_end | output | 1 | Send two ones and an EOF |

## Verification
The assertions check on every cycle that `tx_valid` and `tx_end` are never high together, and that a handed-over byte always comes with transmit-empty set. They also check that SOF clears the ignore bit, that the ignore bit keeps receive-full from being set, that a lost arbitration drops the pending byte and moves the block to receiving, and that message-complete always wins the status encoding. Only the bench scenarios can show the values that pass through: which byte is sent after an overwrite, the byte order inside messages of several lengths, the underrun close, the received byte for every one of the 256 values, and the sequence in which the status code falls back as conditions are read away.

// File: rtl/j1850_link_ctrl.sv
module j1850_link_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dat_we,
  input  logic [DW-1:0] dat_wdata,
  input  logic          dat_re,
  output logic [DW-1:0] dat_rdata,
  input  logic          ctl_we,
  input  logic          ctl_ign_in,
  input  logic          ctl_ie_in,
  output logic          ign_msg,
  input  logic          stat_re,
  output logic [2:0]    stat_vec,
  output logic          irq,
  input  logic          sym_sof,
  input  logic          sym_rx_valid,
  input  logic [DW-1:0] sym_rx_byte,
  input  logic          sym_eof,
  input  logic          sym_lost,
  input  logic          sym_tx_rdy,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  output logic          tx_end
);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX} st_t;

  st_t           st;
  logic [DW-1:0] pend, rxbuf;
  logic          pend_full, ie, ign;
  logic          f_eof, f_lost, f_rxf, f_txe;

  wire take_idle = (st == S_IDLE) && !sym_sof && sym_tx_rdy && pend_full;
  wire take_tx   = (st == S_TX) && !sym_lost && sym_tx_rdy && pend_full;
  wire underrun  = (st == S_TX) && !sym_lost && sym_tx_rdy && !pend_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pend <= '0;
      rxbuf <= '0;
      pend_full <= 1'b0;
      ie <= 1'b0;
      ign <= 1'b0;
      f_eof <= 1'b0;
      f_lost <= 1'b0;
      f_rxf <= 1'b0;
      f_txe <= 1'b0;
      tx_valid <= 1'b0;
      tx_byte <= '0;
      tx_end <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      tx_end <= 1'b0;
      if (dat_we) begin
        pend <= dat_wdata;
        pend_full <= 1'b1;
        f_txe <= 1'b0;
      end
      if (dat_re) f_rxf <= 1'b0;
      if (stat_re) begin
        if (f_eof) f_eof <= 1'b0;
        else if (f_lost) f_lost <= 1'b0;
      end
      if (ctl_we) begin
        ie <= ctl_ie_in;
        ign <= ctl_ign_in;
      end
      if (sym_sof) ign <= 1'b0;

      if (st == S_IDLE && sym_sof) st <= S_RX;
      if (take_idle || take_tx) begin
        tx_valid <= 1'b1;
        tx_byte <= pend;
        pend_full <= 1'b0;
        f_txe <= 1'b1;
        st <= S_TX;
      end
      if (underrun) begin
        tx_end <= 1'b1;
        st <= S_IDLE;
      end
      if (st == S_TX && sym_lost) begin
        st <= S_RX;
        pend_full <= 1'b0;
        f_lost <= 1'b1;
      end

      if (sym_rx_valid && st != S_TX && !ign) begin
        rxbuf <= sym_rx_byte;
        f_rxf <= 1'b1;
      end
      if (sym_eof) begin
        if (!ign) f_eof <= 1'b1;
        st <= S_IDLE;
      end
    end
  end

  assign dat_rdata = rxbuf;
  assign ign_msg   = ign;
  assign stat_vec  = f_eof ? 3'd4 : f_lost ? 3'd3 : f_rxf ? 3'd2 : f_txe ? 3'd1 : 3'd0;
  assign irq       = ie & (f_eof | f_lost | f_rxf | f_txe);

  p_no_dual_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_end));

  p_take_sets_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> f_txe);

  p_sof_clears_ign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sym_sof |=> !ign_msg);

  p_ign_blocks_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ign && sym_rx_valid && !f_rxf) |=> !f_rxf);

  p_lost_to_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && sym_lost && !sym_eof) |=> (st == S_RX && !pend_full && f_lost));

  p_eof_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    f_eof |-> stat_vec == 3'd4);

endmodule

// File: tb/test_j1850_link_ctrl.sv
module test_j1850_link_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dat_we = 0, dat_re = 0, ctl_we = 0, ctl_ign_in = 0, ctl_ie_in = 0, stat_re = 0;
  logic sym_sof = 0, sym_rx_valid = 0, sym_eof = 0, sym_lost = 0, sym_tx_rdy = 0;
  logic [DW-1:0] dat_wdata = '0, sym_rx_byte = '0;
  logic [DW-1:0] dat_rdata, tx_byte;
  logic ign_msg, irq, tx_valid, tx_end;
  logic [2:0] stat_vec;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  j1850_link_ctrl #(.DW(DW)) i_j1850_link_ctrl (
    .clk(clk), .rst_n(rst_n), .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re),
    .dat_rdata(dat_rdata), .ctl_we(ctl_we), .ctl_ign_in(ctl_ign_in), .ctl_ie_in(ctl_ie_in),
    .ign_msg(ign_msg), .stat_re(stat_re), .stat_vec(stat_vec), .irq(irq),
    .sym_sof(sym_sof), .sym_rx_valid(sym_rx_valid), .sym_rx_byte(sym_rx_byte),
    .sym_eof(sym_eof), .sym_lost(sym_lost), .sym_tx_rdy(sym_tx_rdy),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_end(tx_end));

  task automatic tick();
    @(posedge clk); #1;
    dat_we = 0; dat_re = 0; ctl_we = 0; stat_re = 0;
    sym_sof = 0; sym_rx_valid = 0; sym_eof = 0; sym_lost = 0; sym_tx_rdy = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] v); dat_we = 1; dat_wdata = v; tick(); endtask
  task automatic ctl(input logic ig, input logic en); ctl_we = 1; ctl_ign_in = ig; ctl_ie_in = en; tick(); endtask
  task automatic rdy(); sym_tx_rdy = 1; tick(); endtask
  task automatic rxb(input logic [DW-1:0] v); sym_rx_valid = 1; sym_rx_byte = v; tick(); endtask
  task automatic eof(); sym_eof = 1; tick(); endtask
  task automatic sof(); sym_sof = 1; tick(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] b;
    tick(); tick();
    rst_n = 1; tick();
    chk("R1 stat", stat_vec, 0); chk("R1 irq", irq, 0); chk("R1 ign", ign_msg, 0);
    chk("R1 txv", tx_valid, 0); chk("R1 txend", tx_end, 0);

    ctl(0, 1);
    chk("R12 no flag irq", irq, 0);

    for (int len = 1; len <= 4; len++) begin
      wr(8'h11);
      b = 8'(len * 37 + 5) | ((len == 3) ? 8'hFF : 8'h00);
      wr(b);
      chk("R4 write clears empty", stat_vec, 0);
      rdy();
      chk("R2 R3 start valid", tx_valid, 1); chk("R3 overwritten byte", tx_byte, b);
      chk("R4 empty set", stat_vec, 1); chk("R12 irq on empty", irq, 1);
      tick();
      chk("R2 single pulse", tx_valid, 0);
      for (int k = 1; k < len; k++) begin
        b = 8'(len * 53 + k * 29);
        wr(b);
        chk("R4 write clears", stat_vec, 0);
        rdy();
        chk("R4 next valid", tx_valid, 1); chk("R4 next byte", tx_byte, b);
        chk("R4 empty again", stat_vec, 1);
      end
      rdy();
      chk("R5 underrun end", tx_end, 1); chk("R5 no byte", tx_valid, 0);
      tick();
      chk("R5 end pulse", tx_end, 0);
      eof();
      chk("R7 complete", stat_vec, 4);
      stat_re = 1; tick();
      chk("R13 clears complete", stat_vec, 1);
      rdy();
      chk("R5 idle no send", tx_valid + tx_end, 0);
    end

    sof();
    for (int v = 0; v < 256; v++) begin
      rxb(8'(v));
      chk("R6 rx flag", stat_vec, 2); chk("R6 rx byte", dat_rdata, v);
      dat_re = 1; tick();
      chk("R6 read clears", stat_vec, 1);
    end
    eof();
    chk("R7 rx complete", stat_vec, 4);
    stat_re = 1; tick();

    sof();
    ctl(1, 1);
    chk("R9 ign set", ign_msg, 1);
    rxb(8'hAA);
    chk("R8 ign no rx flag", stat_vec, 1); chk("R8 ign rdata kept", dat_rdata, 8'hFF);
    eof();
    chk("R8 ign no complete", stat_vec, 1);
    sof();
    chk("R9 sof clears ign", ign_msg, 0);
    rxb(8'h3C);
    chk("R9 rx after sof", stat_vec, 2); chk("R9 rx byte", dat_rdata, 8'h3C);
    dat_re = 1; tick();
    eof(); stat_re = 1; tick();
    ctl(1, 1);
    ctl(0, 1);
    chk("R9 cpu clears ign", ign_msg, 0);

    wr(8'h55);
    rdy();
    chk("R2 lost msg start", tx_byte, 8'h55);
    ctl(1, 1);
    wr(8'hFF);
    sym_lost = 1; tick();
    chk("R11 lost code", stat_vec, 3); chk("R8 lost not masked", irq, 1);
    ctl(0, 1);
    rdy();
    chk("R11 no send after lost", tx_valid + tx_end, 0);
    rxb(8'h77);
    chk("R10 lost over rx", stat_vec, 3); chk("R11 rx after lost", dat_rdata, 8'h77);
    stat_re = 1; tick();
    chk("R13 lost cleared", stat_vec, 2);
    eof();
    chk("R10 complete over rx", stat_vec, 4); chk("R12 irq", irq, 1);
    ctl(0, 0);
    chk("R12 disabled", irq, 0);
    stat_re = 1; tick();
    chk("R13 back to rx", stat_vec, 2);
    dat_re = 1; tick();
    chk("R10 none", stat_vec, 0);
    ctl(0, 1);
    chk("R12 enabled no flag", irq, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule